// File: doc/BRIEF.md
# Digital Oscillator Trim Counter

This block turns a nominal 32.768 kHz oscillator clock into a one-second tick. It also applies a small signed rate correction, so that a crystal that runs slightly fast or slow still keeps good time over the long run. The correction never touches the oscillator itself. On chosen seconds the divider counts one cycle fewer or one cycle more than nominal. Each 10 ppm step is worth a fixed number of such seconds in every correction window, spread evenly across that window.

A 3-bit trim code sets the correction. The top bit picks the direction and the two low bits give a magnitude of 0 to 3 steps, which covers -30 ppm to +30 ppm. The block samples the code at reset and again at the end of each correction window, so one window never mixes two codes. Besides the tick, the block drives two taps. The 1 Hz tap follows the corrected seconds. The fast tap (4096 Hz at the default settings) comes straight from the oscillator and is never corrected.

Parameters: `CNT_PER_SEC` (M, cycles in a nominal second), `WINDOW_SEC` (W, seconds per correction window), `SLOTS_PER_STEP` (S, adjusted seconds per window for each 10 ppm step) and `FAST_DIV` (oscillator cycles per fast-tap period).

Top module: `otc_trim_counter`

## Requirements
- R1: Right after reset, `sec_tick_o` is 0, `hz1_o` is 1 and `fast_o` is 0, and a new second begins at count 0.
- R2: With magnitude 0 (codes 000 and 100), every second lasts exactly M cycles, and a window lasts W*M cycles.
- R3: Trim code encoding: bit 2 = 1 means faster and bit 2 = 0 means slower. Bits [1:0] form a magnitude m in 0..3. A window holds exactly n = m*S adjusted seconds, so its length is W*M - n when faster and W*M + n when slower.
- R4: When the code is faster, each adjusted second lasts M-1 cycles.
- R5: When the code is slower, each adjusted second lasts M+1 cycles. The internal count never goes above M.
- R6: Second s of a window (counting from 0) is adjusted exactly when floor((s+1)*n/W) > floor(s*n/W). Every other second lasts M cycles.
- R7: The block samples the trim code at reset and at the tick that ends the last second of a window. A change between those points has no effect until the next window starts.
- R8: `sec_tick_o` is high for exactly one cycle: the last cycle of each second.
- R9: `hz1_o` is high for the first M/2 cycles of every second and low for the rest. It is low while the tick is high and high on the cycle after it, whatever the correction.
- R10: `fast_o` is a square wave with period `FAST_DIV` and equal high and low runs. Correction does not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| trim_i | input | 3 | Trim code: bit 2 direction, bits [1:0] magnitude |
| sec_tick_o | output | 1 | One-cycle pulse that ends each corrected second |
| hz1_o | output | 1 | 1 Hz tap, high during the first half of each corrected second |
| fast_o | output | 1 | Uncorrected fast tap, oscillator divided by FAST_DIV |

## Verification
Some properties are checked on every cycle:
- the tick is a single-cycle pulse;
- the 1 Hz tap is low on the tick and rises right after it;
- the second counter stays within M;
- the trim code held inside the block changes only at a window boundary;
- each window holds exactly n adjusted seconds.

Other behaviour only the bench's scenarios can show. These are the exact length of each second against the floor-based schedule, the window totals for each code in both directions, and the delay of a trim change made mid-window until the next window. They also include the undisturbed fast tap during shortened and lengthened seconds.

// File: rtl/otc_pkg.sv
package otc_pkg;

    // Trim code as seen on the input pins.
    typedef struct packed {
        logic       faster;   // 1: shorten adjusted seconds, 0: lengthen them
        logic [1:0] mag;      // number of 10 ppm steps
    } trim_code_t;

    // Length of the current second relative to nominal.
    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_SHORT = 2'd1,
        ADJ_LONG  = 2'd2
    } adj_e;

    // Number of adjusted seconds in one window for a given magnitude.
    function automatic int unsigned slots_for(input logic [1:0] mag,
                                              input int unsigned step);
        return int'(mag) * step;
    endfunction

endpackage

// File: rtl/otc_fast_tap.sv
module otc_fast_tap #(
    parameter int unsigned FAST_DIV = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic fast_o
);
    localparam int unsigned PW = (FAST_DIV < 2) ? 1 : $clog2(FAST_DIV);

    logic [PW-1:0] pre_q;

    // Free-running prescaler; it is never stretched or shortened by the trim.
    always_ff @(posedge clk_i) begin
        if (rst_i) pre_q <= '0;
        else       pre_q <= pre_q + 1'b1;
    end

    generate
        if (FAST_DIV < 2) begin : g_degenerate
            assign fast_o = 1'b0;
        end else begin : g_msb
            assign fast_o = pre_q[PW-1];
        end
    endgenerate

endmodule

// File: rtl/otc_schedule.sv
module otc_schedule
    import otc_pkg::*;
#(
    parameter int unsigned WINDOW_SEC     = 100,
    parameter int unsigned SLOTS_PER_STEP = 33
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [2:0] trim_i,
    input  logic       sec_end_i,
    output adj_e       adj_o
);
    localparam int unsigned AW = $clog2(WINDOW_SEC + 1);
    localparam int unsigned SW = $clog2(WINDOW_SEC + 1);
    localparam logic [SW-1:0] LAST_SEC = SW'(WINDOW_SEC - 1);
    localparam logic [AW:0]   WIN_SUM  = (AW+1)'(WINDOW_SEC);

    trim_code_t     code_q;
    logic [SW-1:0]  sidx_q;
    logic [AW-1:0]  acc_q;
    logic [AW-1:0]  slots;
    logic [AW:0]    sum;
    logic           hit;
    logic           win_end;

    // Error accumulator: one adjusted second each time it passes the window size.
    assign slots   = AW'(slots_for(code_q.mag, SLOTS_PER_STEP));
    assign sum     = {1'b0, acc_q} + {1'b0, slots};
    assign hit     = (sum >= WIN_SUM);
    assign win_end = sec_end_i && (sidx_q == LAST_SEC);

    always_comb begin
        if (!hit)              adj_o = ADJ_NONE;
        else if (code_q.faster) adj_o = ADJ_SHORT;
        else                   adj_o = ADJ_LONG;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            code_q <= trim_code_t'(trim_i);
            sidx_q <= '0;
            acc_q  <= '0;
        end else if (win_end) begin
            code_q <= trim_code_t'(trim_i);
            sidx_q <= '0;
            acc_q  <= '0;
        end else if (sec_end_i) begin
            sidx_q <= sidx_q + 1'b1;
            acc_q  <= hit ? AW'(sum - WIN_SUM) : AW'(sum);
        end
    end

    // Checker: count adjusted seconds seen in the current window.
    logic [AW-1:0] seen_q;
    always_ff @(posedge clk_i) begin
        if (rst_i || win_end) seen_q <= '0;
        else if (sec_end_i && hit) seen_q <= seen_q + 1'b1;
    end

    AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !win_end |=> $stable(code_q)); // R7

    AST_ADJ_TOTAL: assert property (@(posedge clk_i) disable iff (rst_i)
        win_end |-> (int'(seen_q) + int'(hit)) == int'(slots)); // R6

endmodule

// File: rtl/otc_sec_div.sv
module otc_sec_div
    import otc_pkg::*;
#(
    parameter int unsigned CNT_PER_SEC = 32768
) (
    input  logic clk_i,
    input  logic rst_i,
    input  adj_e adj_i,
    output logic sec_end_o,
    output logic hz1_o
);
    localparam int unsigned CW = $clog2(CNT_PER_SEC + 1);
    localparam logic [CW-1:0] LAST_NOM   = CW'(CNT_PER_SEC - 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(CNT_PER_SEC - 2);
    localparam logic [CW-1:0] LAST_LONG  = CW'(CNT_PER_SEC);
    localparam logic [CW-1:0] HALF       = CW'(CNT_PER_SEC / 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        unique case (adj_i)
            ADJ_SHORT: last = LAST_SHORT;
            ADJ_LONG:  last = LAST_LONG;
            default:   last = LAST_NOM;
        endcase
    end

    assign sec_end_o = (cnt_q == last);
    assign hz1_o     = (cnt_q < HALF);

    always_ff @(posedge clk_i) begin
        if (rst_i)          cnt_q <= '0;
        else if (sec_end_o) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST_LONG); // R5

endmodule

// File: rtl/otc_trim_counter.sv
module otc_trim_counter
    import otc_pkg::*;
#(
    parameter int unsigned CNT_PER_SEC    = 32768,
    parameter int unsigned WINDOW_SEC     = 100,
    parameter int unsigned SLOTS_PER_STEP = 33,
    parameter int unsigned FAST_DIV       = 8
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [2:0] trim_i,
    output logic       sec_tick_o,
    output logic       hz1_o,
    output logic       fast_o
);
    adj_e adj;
    logic sec_end;

    otc_schedule #(
        .WINDOW_SEC     (WINDOW_SEC),
        .SLOTS_PER_STEP (SLOTS_PER_STEP)
    ) sched_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .trim_i    (trim_i),
        .sec_end_i (sec_end),
        .adj_o     (adj)
    );

    otc_sec_div #(
        .CNT_PER_SEC (CNT_PER_SEC)
    ) div_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .adj_i     (adj),
        .sec_end_o (sec_end),
        .hz1_o     (hz1_o)
    );

    otc_fast_tap #(
        .FAST_DIV (FAST_DIV)
    ) fast_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .fast_o (fast_o)
    );

    assign sec_tick_o = sec_end;

    AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        sec_tick_o |=> !sec_tick_o); // R8

    AST_HZ1_LOW_AT_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        sec_tick_o |-> !hz1_o); // R9

    AST_HZ1_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        sec_tick_o |=> hz1_o); // R9

endmodule

// File: tb/otc_trim_counter_tb_top.sv
module otc_trim_counter_tb_top;

    localparam int M  = 64;
    localparam int W  = 10;
    localparam int S  = 3;
    localparam int FD = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] trim = 3'b000;
    logic       tick, hz1, fast;

    int checks = 0;
    int failures = 0;

    // Bench model state
    int         k = 0;
    logic [2:0] win_code = 3'b000;
    int         win_total = 0;
    logic       fast_prev = 1'b0;
    int         run = 0;
    bit         run_valid = 0;

    always #4 clk = ~clk;

    otc_trim_counter #(
        .CNT_PER_SEC    (M),
        .WINDOW_SEC     (W),
        .SLOTS_PER_STEP (S),
        .FAST_DIV       (FD)
    ) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .trim_i     (trim),
        .sec_tick_o (tick),
        .hz1_o      (hz1),
        .fast_o     (fast)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset with a given trim code; checks the reset state (R1).
    task automatic t_reset(input logic [2:0] code);
        trim = code;
        rst  = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(tick == 1'b0, "R1 tick", int'(tick), 0);
        chk(hz1  == 1'b1, "R1 hz1",  int'(hz1),  1);
        chk(fast == 1'b0, "R1 fast", int'(fast), 0);
        k = 0; win_code = code; win_total = 0;
        fast_prev = 1'b0; run = 0; run_valid = 0;
    endtask

    // Observe one full second and check its length, taps and window totals.
    task automatic step_second();
        int  len = 0;
        int  hi = 0;
        bit  fast_bad = 0;
        int  s, n, exp_len, exp_tot;
        bit  adj;
        string lbl;
        forever begin
            len++;
            if (hz1) hi++;
            if (fast == fast_prev) run++;
            else begin
                if (run_valid && run != FD/2) fast_bad = 1;
                run_valid = 1;
                run = 1;
                fast_prev = fast;
            end
            if (tick) break;
            @(negedge clk);
        end
        @(negedge clk);
        chk(tick == 1'b0, "R8 tick width", int'(tick), 0);
        s = k % W;
        n = int'(win_code[1:0]) * S;
        adj = (((s + 1) * n) / W) > ((s * n) / W);
        exp_len = M + (adj ? (win_code[2] ? -1 : 1) : 0);
        if (n == 0)      lbl = "R2 second length";
        else if (adj)    lbl = win_code[2] ? "R4 short second" : "R5 long second";
        else             lbl = "R6 nominal second";
        chk(len == exp_len, lbl, len, exp_len);
        chk(hi == M/2, "R9 hz1 high count", hi, M/2);
        chk(!fast_bad, "R10 fast run", int'(fast_bad), 0);
        win_total += len;
        if (s == W - 1) begin
            exp_tot = W * M + (win_code[2] ? -n : n);
            chk(win_total == exp_tot, "R3 window total", win_total, exp_tot);
            win_total = 0;
            win_code  = trim;
        end
        k++;
    endtask

    task automatic t_windows(input int nwin);
        repeat (nwin * W) step_second();
    endtask

    // Code change in mid-window must wait for the next window (R7).
    task automatic t_mid_change();
        int f0;
        t_reset(3'b001);
        repeat (W/2) step_second();
        trim = 3'b110;
        f0 = failures;
        repeat (W - W/2) step_second();
        chk(failures == f0, "R7 old code kept to window end", failures - f0, 0);
        f0 = failures;
        t_windows(2);
        chk(failures == f0, "R7 new code from next window", failures - f0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset(3'b000); t_windows(2);   // R2 zero correction
        t_reset(3'b101); t_windows(2);   // R4 +10 ppm
        t_reset(3'b111); t_windows(2);   // R4 +30 ppm
        t_reset(3'b010); t_windows(2);   // R5 -20 ppm
        t_reset(3'b011); t_windows(2);   // R5 -30 ppm
        t_reset(3'b100); t_windows(1);   // R2 sign with zero magnitude
        t_mid_change();                  // R7
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule